// File: doc/BRIEF.md
# Cascaded Serial Attenuator Programmer

This block is the host side of a shared three-wire serial bus (data, clock, latch enable) that programs a chain of `NUM_DEV` step attenuators. Each device takes a 6-bit attenuation code. All codes arrive together on one flat input vector and are captured when a request is accepted. The engine pads each code with two leading don't-care bits to form an 8-bit word. It shifts the whole frame out most significant bit first, starting with the word for the device farthest from the host. It then raises latch enable once, so that every device in the chain takes its new state at the same moment.

Every interval the devices need is given as a parameter in nanoseconds, together with the system clock period. These intervals are the minimum clock period, the data setup and hold around each rising clock edge, the delay from the last clock edge to latch, the latch pulse width and the spacing between latch pulses. Each one is rounded up to whole system-clock cycles. A request is accepted only when the engine is idle and the latch-spacing window has run out. `busy` covers the whole of that time, and `done` pulses once per completed frame.

Top module: `atten_chain_host`

## Requirements
- R1: After reset, `sClk`, `latchEn`, `done`, `busy` and `sData` are all low.
- R2: A frame is exactly `NUM_DEV*8` rising edges of `sClk`. The code for device d sits in `codes[6d+5:6d]`, and device `NUM_DEV-1` is the farthest from the host. Words go out for device `NUM_DEV-1` first and device 0 last. Each word is two pad bits of value 0 followed by code bit 5 down to bit 0, and `sData` is read at each rising `sClk` edge.
- R3: The spacing between any two rising `sClk` edges is at least `SCK_NS`.
- R4: `sData` is stable for at least `SETUP_NS` before each rising `sClk` edge and for at least `HOLD_NS` after it.
- R5: `latchEn` is low at every rising `sClk` edge.
- R6: After the last rising `sClk` edge of a frame, `latchEn` rises exactly once. It rises no sooner than `LE_SETUP_NS` after that edge and stays high for at least `LE_WIDTH_NS`.
- R7: `done` is high for one cycle per frame, in the first cycle in which `latchEn` has fallen back low.
- R8: `busy` is high from the cycle after acceptance until `ceil(LE_SPACE_NS/CLK_NS)` cycles after `latchEn` rises (63 cycles with the defaults). While `busy` is high, `startValid` is ignored: no clock edge and no `done` follow from it.
- R9: `codes` is captured in the cycle of acceptance. Changing `codes` later does not alter the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Request; taken when `busy` is low |
| codes | input | NUM_DEV*6 | Attenuation codes, device d in bits [6d+5:6d] |
| busy | output | 1 | Frame in progress or latch spacing not yet expired |
| done | output | 1 | One-cycle pulse after the latch pulse ends |
| sData | output | 1 | Serial data to the first device |
| sClk | output | 1 | Serial clock |
| latchEn | output | 1 | Latch enable shared by all devices |

## Verification
The frame is driven with all-zero and all-one codes, with alternating bit patterns, and with codes that differ between the two devices. Each pattern is recovered bit by bit at the rising clock edges. The all-zero and all-one cases separate the pad bits from the code bits. The mixed codes expose any swap of device order or bit order. After every start the code input is overwritten with its complement, which shows whether the codes were captured at acceptance. Each frame is also measured for clock spacing, setup, hold, latch placement, `done` timing and the length of the spacing window. During one window the request is held high, to confirm that nothing starts.

// File: rtl/atten_pkg.sv
package atten_pkg;

  // Round a nanosecond interval up to whole clock cycles.
  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_LESU,
    ST_LATCH
  } hostState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;
    logic shift;
  } shiftStrb_t;

endpackage

// File: rtl/atten_shifter.sv
module atten_shifter
  import atten_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int CODE_W  = 6,
  parameter int WORD_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_DEV*CODE_W-1:0] codes,
  input  shiftStrb_t                strb,
  output logic                      sData
);

  localparam int FRAME_BITS = NUM_DEV * WORD_W;
  localparam int PAD_W      = WORD_W - CODE_W;

  logic [FRAME_BITS-1:0] frameWord;
  logic [FRAME_BITS-1:0] shReg;

  // Device d occupies slot d; the highest slot leaves first (farthest device).
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_slot
    assign frameWord[d*WORD_W +: WORD_W] = {{PAD_W{1'b0}}, codes[d*CODE_W +: CODE_W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shReg <= '0;
    end else if (strb.load) begin
      shReg <= frameWord;
    end else if (strb.shift) begin
      shReg <= {shReg[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign sData = shReg[FRAME_BITS-1];

endmodule

// File: rtl/atten_ctrl.sv
module atten_ctrl
  import atten_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int LOW_C      = 3,
  parameter int HIGH_C     = 4,
  parameter int LES_C      = 2,
  parameter int LEW_C      = 1,
  parameter int SPACE_C    = 63
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startValid,
  output logic       busy,
  output logic       done,
  output logic       sClk,
  output logic       latchEn,
  output shiftStrb_t strb
);

  localparam int PH_MAX = imax(imax(LOW_C, HIGH_C), imax(LES_C, LEW_C));
  localparam int PH_W   = imax(1, $clog2(PH_MAX + 1));
  localparam int BIT_W  = imax(1, $clog2(FRAME_BITS));
  localparam int SP_W   = imax(1, $clog2(SPACE_C + 1));

  localparam logic [PH_W-1:0]  LOW_LD   = PH_W'(LOW_C - 1);
  localparam logic [PH_W-1:0]  HIGH_LD  = PH_W'(HIGH_C - 1);
  localparam logic [PH_W-1:0]  LES_LD   = PH_W'(LES_C - 1);
  localparam logic [PH_W-1:0]  LEW_LD   = PH_W'(LEW_C - 1);
  localparam logic [BIT_W-1:0] BIT_LD   = BIT_W'(FRAME_BITS - 1);
  localparam logic [SP_W-1:0]  SPACE_LD = SP_W'(SPACE_C);

  hostState_t       state;
  logic [PH_W-1:0]  phaseCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [SP_W-1:0]  spaceCnt;
  logic             phaseEnd;
  logic             accept;

  assign phaseEnd = (phaseCnt == '0);
  assign busy     = (state != ST_IDLE) || (spaceCnt != '0);
  assign accept   = (state == ST_IDLE) && startValid && (spaceCnt == '0);

  always_comb begin
    strb.load  = accept;
    strb.shift = (state == ST_HIGH) && phaseEnd && (bitCnt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitCnt   <= '0;
      spaceCnt <= '0;
      sClk     <= 1'b0;
      latchEn  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (spaceCnt != '0) spaceCnt <= spaceCnt - 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_LOW;
            phaseCnt <= LOW_LD;
            bitCnt   <= BIT_LD;
          end
        end
        ST_LOW: begin
          if (phaseEnd) begin
            state    <= ST_HIGH;
            phaseCnt <= HIGH_LD;
            sClk     <= 1'b1;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            sClk <= 1'b0;
            if (bitCnt == '0) begin
              state    <= ST_LESU;
              phaseCnt <= LES_LD;
            end else begin
              state    <= ST_LOW;
              phaseCnt <= LOW_LD;
              bitCnt   <= bitCnt - 1'b1;
            end
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_LESU: begin
          if (phaseEnd) begin
            state    <= ST_LATCH;
            phaseCnt <= LEW_LD;
            latchEn  <= 1'b1;
            spaceCnt <= SPACE_LD;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_LATCH: begin
          if (phaseEnd) begin
            state   <= ST_IDLE;
            latchEn <= 1'b0;
            done    <= 1'b1;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/atten_chain_host.sv
module atten_chain_host
  import atten_pkg::*;
#(
  parameter int NUM_DEV     = 2,
  parameter int CODE_W      = 6,
  parameter int WORD_W      = 8,
  parameter int CLK_NS      = 10,
  parameter int SCK_NS      = 70,
  parameter int SETUP_NS    = 15,
  parameter int HOLD_NS     = 20,
  parameter int LE_SETUP_NS = 15,
  parameter int LE_WIDTH_NS = 10,
  parameter int LE_SPACE_NS = 630
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      startValid,
  input  logic [NUM_DEV*CODE_W-1:0] codes,
  output logic                      busy,
  output logic                      done,
  output logic                      sData,
  output logic                      sClk,
  output logic                      latchEn
);

  localparam int FRAME_BITS = NUM_DEV * WORD_W;
  localparam int SCK_C      = cdiv(SCK_NS, CLK_NS);
  localparam int SETUP_C    = cdiv(SETUP_NS, CLK_NS);
  localparam int HOLD_C     = cdiv(HOLD_NS, CLK_NS);
  // The high phase also covers hold, since data moves only at its end.
  localparam int HIGH_C     = imax(1, imax(cdiv(SCK_C, 2), HOLD_C));
  localparam int LOW_C      = imax(1, imax(SETUP_C, SCK_C - HIGH_C));
  localparam int LES_C      = imax(1, cdiv(LE_SETUP_NS, CLK_NS));
  localparam int LEW_C      = imax(1, cdiv(LE_WIDTH_NS, CLK_NS));
  localparam int SPACE_C    = imax(1, cdiv(LE_SPACE_NS, CLK_NS));

  shiftStrb_t strb;

  atten_ctrl #(
    .FRAME_BITS(FRAME_BITS),
    .LOW_C     (LOW_C),
    .HIGH_C    (HIGH_C),
    .LES_C     (LES_C),
    .LEW_C     (LEW_C),
    .SPACE_C   (SPACE_C)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .startValid(startValid),
    .busy      (busy),
    .done      (done),
    .sClk      (sClk),
    .latchEn   (latchEn),
    .strb      (strb)
  );

  atten_shifter #(
    .NUM_DEV(NUM_DEV),
    .CODE_W (CODE_W),
    .WORD_W (WORD_W)
  ) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .codes(codes),
    .strb (strb),
    .sData(sData)
  );

endmodule

// File: rtl/atten_chain_host_chk.sv
module atten_chain_host_chk #(
  parameter int FRAME_BITS = 16,
  parameter int CLK_NS     = 10,
  parameter int HOLD_NS    = 20
) (
  input logic clk,
  input logic rst_n,
  input logic startValid,
  input logic busy,
  input logic done,
  input logic sData,
  input logic sClk,
  input logic latchEn
);

  logic [15:0] highLen;
  logic [15:0] riseCnt;
  logic        sClkQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      highLen <= '0;
      riseCnt <= '0;
      sClkQ   <= 1'b0;
    end else begin
      sClkQ   <= sClk;
      highLen <= sClk ? highLen + 1'b1 : '0;
      if (latchEn)             riseCnt <= '0;
      else if (sClk && !sClkQ) riseCnt <= riseCnt + 1'b1;
    end
  end

  // R5: latch stays low while the clock is high
  a_r5_latch_low_on_clk: assert property (@(posedge clk) disable iff (!rst_n)
    sClk |-> !latchEn);

  // R4: data does not move while the clock is high
  a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    sClk |-> $stable(sData));

  // R4: the high phase is long enough to cover hold
  a_r4_hold_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sClk) |-> (32'(highLen) * CLK_NS >= HOLD_NS));

  // R2: one latch per full frame of clock edges
  a_r2_frame_edges: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latchEn) |-> (32'(riseCnt) == FRAME_BITS));

  // R7: done follows the falling latch
  a_r7_done_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(latchEn) && !latchEn));

  // R8: an accepted request makes the engine busy
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (startValid && !busy) |=> busy);

  // R8: the bus is quiet when not busy
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sClk && !latchEn));

endmodule

bind atten_chain_host atten_chain_host_chk #(
  .FRAME_BITS(NUM_DEV * WORD_W),
  .CLK_NS    (CLK_NS),
  .HOLD_NS   (HOLD_NS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .startValid(startValid),
  .busy      (busy),
  .done      (done),
  .sData     (sData),
  .sClk      (sClk),
  .latchEn   (latchEn)
);

// File: tb/atten_chain_host_test.sv
`timescale 1ns/1ps
module atten_chain_host_test;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_DEV    = 2;
  localparam int FRAME      = NUM_DEV * 8;
  localparam int SCK_NS     = 70;
  localparam int SETUP_NS   = 15;
  localparam int HOLD_NS    = 20;
  localparam int LES_NS     = 15;
  localparam int LEW_NS     = 10;
  localparam int SPACE_NS   = 630;
  localparam int SPACE_CYC  = (SPACE_NS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int NVEC       = 4;
  localparam logic [11:0] VEC [NVEC] = '{12'h000, 12'hFFF, 12'hA95, 12'h3C1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startValid = 1'b0;
  logic [NUM_DEV*6-1:0] codes = '0;
  logic busy, done, sData, sClk, latchEn;

  atten_chain_host #(.NUM_DEV(NUM_DEV), .CLK_NS(CLK_PERIOD)) uut (
    .clk(clk), .rst_n(rst_n), .startValid(startValid), .codes(codes),
    .busy(busy), .done(done), .sData(sData), .sClk(sClk), .latchEn(latchEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int fails = 0;

  // Monitor state, written only by the monitor process.
  int rises = 0, setupBad = 0, holdBad = 0, periodBad = 0, latchClkBad = 0;
  int leRises = 0, leSetupBad = 0, leWidthBad = 0, dones = 0, doneBad = 0;
  int stableCnt = 0, sinceRise = 1000, leHigh = 0, spCnt = 0, spResult = -1;
  logic spActive = 1'b0;
  logic prevS = 1'b0, prevLe = 1'b0, prevD = 1'b0;
  logic [63:0] cap = '0;

  always @(negedge clk) begin
    int gap;
    if (!rst_n) begin
      prevS = 1'b0; prevLe = 1'b0; prevD = sData;
      stableCnt = 0; sinceRise = 1000; spActive = 1'b0;
    end else begin
      gap = (sinceRise < 1000) ? sinceRise + 1 : 1000;
      if (sData !== prevD) begin
        if (gap * CLK_PERIOD < HOLD_NS) holdBad++;
        stableCnt = 0;
      end else if (stableCnt < 1000) begin
        stableCnt++;
      end
      if (sClk && !prevS) begin
        rises++;
        if (stableCnt * CLK_PERIOD < SETUP_NS) setupBad++;
        if (gap * CLK_PERIOD < SCK_NS) periodBad++;
        if (latchEn) latchClkBad++;
        cap = {cap[62:0], sData};
      end
      if (latchEn && !prevLe) begin
        leRises++;
        if (gap * CLK_PERIOD < LES_NS) leSetupBad++;
        leHigh = 0;
        spActive = 1'b1;
        spCnt = 0;
      end else if (spActive) begin
        spCnt++;
      end
      if (spActive && !busy) begin
        spActive = 1'b0;
        spResult = spCnt;
      end
      sinceRise = (sClk && !prevS) ? 0 : gap;
      if (latchEn) leHigh++;
      if (!latchEn && prevLe && (leHigh * CLK_PERIOD < LEW_NS)) leWidthBad++;
      if (done) begin
        dones++;
        if (!(prevLe && !latchEn)) doneBad++;
      end
      prevS = sClk; prevLe = latchEn; prevD = sData;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected serial sequence: farthest device first, two zero pads, then bit 5..0.
  function automatic logic [FRAME-1:0] expFrame(input logic [NUM_DEV*6-1:0] c);
    logic [FRAME-1:0] f = '0;
    for (int d = NUM_DEV - 1; d >= 0; d--) begin
      f = {f[FRAME-2:0], 1'b0};
      f = {f[FRAME-2:0], 1'b0};
      for (int b = 5; b >= 0; b--) f = {f[FRAME-2:0], c[d*6 + b]};
    end
    return f;
  endfunction

  task automatic runFrame(input logic [NUM_DEV*6-1:0] c, input bit probeBusy);
    int r0, su0, ho0, pe0, lc0, le0, ls0, lw0, dn0, db0, r1, dn1;
    bit stayedBusy;
    @(negedge clk);
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
    r0 = rises; su0 = setupBad; ho0 = holdBad; pe0 = periodBad; lc0 = latchClkBad;
    le0 = leRises; ls0 = leSetupBad; lw0 = leWidthBad; dn0 = dones; db0 = doneBad;
    codes = c;
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    codes = ~c;
    for (int k = 0; k < 2000 && dones == dn0; k++) @(negedge clk);
    if (probeBusy) begin
      r1 = rises; dn1 = dones; stayedBusy = 1'b1;
      codes = '1;
      startValid = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (!busy) stayedBusy = 1'b0;
      end
      startValid = 1'b0;
      check(stayedBusy, "R8 busy held in spacing window", int'(stayedBusy), 1);
      check(rises == r1, "R8 request ignored, clock edges", rises - r1, 0);
      check(dones == dn1, "R8 request ignored, done pulses", dones - dn1, 0);
    end
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
    @(negedge clk);
    check(cap[FRAME-1:0] == expFrame(c), "R2 R9 frame content",
          int'(cap[FRAME-1:0]), int'(expFrame(c)));
    check(rises - r0 == FRAME, "R2 clock edge count", rises - r0, FRAME);
    check(periodBad == pe0, "R3 serial period", periodBad - pe0, 0);
    check(setupBad == su0, "R4 data setup", setupBad - su0, 0);
    check(holdBad == ho0, "R4 data hold", holdBad - ho0, 0);
    check(latchClkBad == lc0, "R5 latch low at clock edge", latchClkBad - lc0, 0);
    check(leRises - le0 == 1, "R6 single latch pulse", leRises - le0, 1);
    check(leSetupBad == ls0, "R6 latch setup", leSetupBad - ls0, 0);
    check(leWidthBad == lw0, "R6 latch width", leWidthBad - lw0, 0);
    check(dones - dn0 == 1, "R7 done count", dones - dn0, 1);
    check(doneBad == db0, "R7 done after latch fall", doneBad - db0, 0);
    check(spResult == SPACE_CYC, "R8 spacing window", spResult, SPACE_CYC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during and just after reset
    check(!sClk && !latchEn, "R1 bus low in reset", int'({sClk, latchEn}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sClk == 1'b0, "R1 sClk after reset", int'(sClk), 0);
    check(latchEn == 1'b0, "R1 latchEn after reset", int'(latchEn), 0);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(sData == 1'b0, "R1 sData after reset", int'(sData), 0);

    for (int i = 0; i < NVEC; i++) runFrame(VEC[i], 1'b0);

    // R8 corner: request held during the spacing window
    runFrame(12'h5A7, 1'b1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule